// File: doc/BRIEF.md
# Multi-channel PWM with shared prescalers

This block generates eight pulse-width-modulated outputs from three shared timebase groups. Each group divides a reference tick by a 16-bit prescale value and then counts a cycle counter from zero up to an 8-bit limit. The group's tick comes from either a fast or a slow reference, chosen per group. Each channel picks one group with a 2-bit code. It compares that group's cycle count with its own 8-bit duty value and can be inverted or gated on its own.

Software programs the block through a byte-wide register port. Writes are synchronous and reads are combinational on the same address bus. The two references arrive as single-cycle clock-enable ticks in the core clock domain. New prescale, cycle-limit and duty values take effect only at the end of the running cycle, so a reprogramming never produces a runt pulse. While the global run bit is clear, every output sits at its idle level and new values are taken at once.

Top module: `pwm_bank`

## Requirements
- R1: After reset the gate register reads 0xFF, every other register reads 0x00, and every output is low.
- R2: Register map: duty of channel n at 0x00+n; group codes of channels 0–3 at 0x08 and of channels 4–7 at 0x09; gate at 0x0A; polarity at 0x0B; reference select at 0x0C; control at 0x0D; group g (1..3) at 0x10+4·(g−1), with the prescale low byte at +0, the prescale high byte at +1 and the cycle limit at +2. Every written register reads back its value. Unmapped addresses read 0x00.
- R3: A group with prescale P and cycle limit C repeats every (P+1)·(C+1) reference ticks. Both prescale bytes count.
- R4: Within one period, a channel with duty D is active for min(D, C+1)·(P+1) ticks. It is active while the group's cycle count is below D.
- R5: A duty of 0 keeps the channel inactive.
- R6: Bit n of the polarity register inverts channel n, so its active level becomes low.
- R7: Bit n of the gate register set forces channel n to its idle level, which equals its polarity bit. Other channels are not affected.
- R8: Control bit 1 is the run bit. While it is clear, every output equals its polarity bit, all counters are held at zero, and written values are taken at once.
- R9: Channel n's 2-bit group code sits at bits (n mod 4)·2 of its select register. Codes 1, 2 and 3 pick a group. Code 0 keeps the channel at its idle level.
- R10: Bit g (g = 1..3) of the reference select register set clocks group g from the fast tick. Cleared, it clocks group g from the slow tick.
- R11: While running, writes to the prescale, cycle-limit and duty registers take effect at the next wrap of the affected group's cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register address for write and read |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr (combinational) |
| fastTick | input | 1 | Fast reference clock enable |
| slowTick | input | 1 | Slow reference clock enable |
| pwmOut | output | 8 | Channel outputs |

## Verification
The outputs are measured over windows of whole periods. Counting the active samples isolates the duty arithmetic from phase, and counting rising edges isolates the period, which tells a fast-clocked group from a slow-clocked one with the same duty ratio. Channels run in three groups with different prescale and limit values, so a wrong group decode or a field at the wrong offset changes a count. Zero duty, duty above the limit, group code 0, inversion, gating and the stopped state each show up as a constant level. A mid-period duty write followed by a high-count window before the wrap and a zero-count window after it separates a deferred update from an immediate one.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_CH    = 8;
  localparam int NUM_GRP   = 3;
  localparam int SEL_W     = 2;
  localparam int DUTY_W    = 8;
  localparam int PRE_W     = 16;
  localparam int CYC_W     = 8;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int SEL_CODES = 1 << SEL_W;
  localparam int SEL_PER_REG = DATA_W / SEL_W;

  // register addresses
  localparam int A_DUTY0   = 'h00;
  localparam int A_SEL_LO  = 'h08;
  localparam int A_SEL_HI  = 'h09;
  localparam int A_GATE    = 'h0A;
  localparam int A_POL     = 'h0B;
  localparam int A_FSEL    = 'h0C;
  localparam int A_CTRL    = 'h0D;
  localparam int A_GRP1    = 'h10;
  localparam int GRP_STRIDE = 4;
  localparam int RUN_BIT   = 1;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [CYC_W-1:0] cyc;
  } grpCfg_t;

  typedef struct packed {
    logic               run;
    logic [NUM_GRP-1:0] fastSel;
  } ctlStrb_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          wrEn,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_CH-1:0][DUTY_W-1:0] dutySh,
  output logic [NUM_CH-1:0][SEL_W-1:0]  grpSel,
  output logic [NUM_CH-1:0]             gateMask,
  output logic [NUM_CH-1:0]             polMask,
  output grpCfg_t [NUM_GRP-1:0]         grpCfg,
  output ctlStrb_t                      strb
);
  logic [NUM_CH-1:0][DUTY_W-1:0] dutyQ;
  logic [NUM_CH-1:0][SEL_W-1:0]  selQ;
  logic [NUM_CH-1:0]             gateQ;
  logic [NUM_CH-1:0]             polQ;
  logic [NUM_GRP-1:0]            fastQ;
  logic                          runQ;
  logic [NUM_GRP-1:0][PRE_W-1:0] preQ;
  logic [NUM_GRP-1:0][CYC_W-1:0] cycQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyQ <= '0;
      selQ  <= '0;
      gateQ <= '1;
      polQ  <= '0;
      fastQ <= '0;
      runQ  <= 1'b0;
      preQ  <= '0;
      cycQ  <= '0;
    end else if (wrEn) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (regAddr == ADDR_W'(A_DUTY0 + ch)) dutyQ[ch] <= wrData[DUTY_W-1:0];
      end
      for (int g = 0; g < NUM_GRP; g++) begin
        if (regAddr == ADDR_W'(A_GRP1 + g * GRP_STRIDE))
          preQ[g][DATA_W-1:0] <= wrData;
        if (regAddr == ADDR_W'(A_GRP1 + g * GRP_STRIDE + 1))
          preQ[g][PRE_W-1:DATA_W] <= wrData;
        if (regAddr == ADDR_W'(A_GRP1 + g * GRP_STRIDE + 2))
          cycQ[g] <= wrData[CYC_W-1:0];
      end
      if (regAddr == ADDR_W'(A_SEL_LO)) selQ[SEL_PER_REG-1:0] <= wrData;
      if (regAddr == ADDR_W'(A_SEL_HI)) selQ[NUM_CH-1:SEL_PER_REG] <= wrData;
      if (regAddr == ADDR_W'(A_GATE))   gateQ <= wrData[NUM_CH-1:0];
      if (regAddr == ADDR_W'(A_POL))    polQ  <= wrData[NUM_CH-1:0];
      if (regAddr == ADDR_W'(A_FSEL))   fastQ <= wrData[NUM_GRP:1];
      if (regAddr == ADDR_W'(A_CTRL))   runQ  <= wrData[RUN_BIT];
    end
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (regAddr == ADDR_W'(A_DUTY0 + ch)) rdData[DUTY_W-1:0] = dutyQ[ch];
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (regAddr == ADDR_W'(A_GRP1 + g * GRP_STRIDE))
        rdData = preQ[g][DATA_W-1:0];
      if (regAddr == ADDR_W'(A_GRP1 + g * GRP_STRIDE + 1))
        rdData = preQ[g][PRE_W-1:DATA_W];
      if (regAddr == ADDR_W'(A_GRP1 + g * GRP_STRIDE + 2))
        rdData[CYC_W-1:0] = cycQ[g];
    end
    if (regAddr == ADDR_W'(A_SEL_LO)) rdData = selQ[SEL_PER_REG-1:0];
    if (regAddr == ADDR_W'(A_SEL_HI)) rdData = selQ[NUM_CH-1:SEL_PER_REG];
    if (regAddr == ADDR_W'(A_GATE))   rdData[NUM_CH-1:0] = gateQ;
    if (regAddr == ADDR_W'(A_POL))    rdData[NUM_CH-1:0] = polQ;
    if (regAddr == ADDR_W'(A_FSEL))   rdData[NUM_GRP:1] = fastQ;
    if (regAddr == ADDR_W'(A_CTRL))   rdData[RUN_BIT] = runQ;
  end

  assign dutySh   = dutyQ;
  assign grpSel   = selQ;
  assign gateMask = gateQ;
  assign polMask  = polQ;
  assign strb.run     = runQ;
  assign strb.fastSel = fastQ;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_cfg
    assign grpCfg[g].pre = preQ[g];
    assign grpCfg[g].cyc = cycQ[g];
  end
endmodule

// File: rtl/pwm_grp_timer.sv
module pwm_grp_timer
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             tick,
  input  grpCfg_t          cfg,
  output logic [CYC_W-1:0] cycCnt,
  output logic             wrap
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preAct;
  logic [CYC_W-1:0] cycAct;
  logic             preEnd;

  assign preEnd = (preCnt == preAct);
  assign wrap   = run && tick && preEnd && (cycCnt == cycAct);

  // limits are copied from the shadow only at a wrap or while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cycCnt <= '0;
      preAct <= '0;
      cycAct <= '0;
    end else if (!run) begin
      preCnt <= '0;
      cycCnt <= '0;
      preAct <= cfg.pre;
      cycAct <= cfg.cyc;
    end else if (tick) begin
      if (preEnd) begin
        preCnt <= '0;
        if (cycCnt == cycAct) begin
          cycCnt <= '0;
          preAct <= cfg.pre;
          cycAct <= cfg.cyc;
        end else begin
          cycCnt <= cycCnt + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          fastTick,
  input  logic                          slowTick,
  input  ctlStrb_t                      strb,
  input  grpCfg_t [NUM_GRP-1:0]         grpCfg,
  input  logic [NUM_CH-1:0][DUTY_W-1:0] dutySh,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  grpSel,
  input  logic [NUM_CH-1:0]             gateMask,
  input  logic [NUM_CH-1:0]             polMask,
  output logic [NUM_CH-1:0]             pwmOut
);
  // index 0 is the "no group" code: count stays zero, never wraps
  logic [CYC_W-1:0] cycBySel  [SEL_CODES];
  logic             wrapBySel [SEL_CODES];

  assign cycBySel[0]  = '0;
  assign wrapBySel[0] = 1'b0;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic grpTick;
    assign grpTick = strb.fastSel[g] ? fastTick : slowTick;

    pwm_grp_timer u_timer (
      .clk    (clk),
      .rstN   (rstN),
      .run    (strb.run),
      .tick   (grpTick),
      .cfg    (grpCfg[g]),
      .cycCnt (cycBySel[g+1]),
      .wrap   (wrapBySel[g+1])
    );
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SEL_W-1:0]  sel;
    logic              hasGrp;
    logic              loadNow;
    logic              isActive;
    logic [DUTY_W-1:0] dutyAct;

    assign sel     = grpSel[ch];
    assign hasGrp  = (sel != '0);
    assign loadNow = !strb.run || gateMask[ch] || !hasGrp || wrapBySel[sel];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        dutyAct <= '0;
      else if (loadNow) dutyAct <= dutySh[ch];
    end

    assign isActive   = strb.run && !gateMask[ch] && hasGrp && (cycBySel[sel] < dutyAct);
    assign pwmOut[ch] = isActive ^ polMask[ch];
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              fastTick,
  input  logic              slowTick,
  output logic [NUM_CH-1:0] pwmOut
);
  logic [NUM_CH-1:0][DUTY_W-1:0] dutySh;
  logic [NUM_CH-1:0][SEL_W-1:0]  grpSel;
  logic [NUM_CH-1:0]             gateMask;
  logic [NUM_CH-1:0]             polMask;
  grpCfg_t [NUM_GRP-1:0]         grpCfg;
  ctlStrb_t                      ctlStrb;

  pwm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .dutySh   (dutySh),
    .grpSel   (grpSel),
    .gateMask (gateMask),
    .polMask  (polMask),
    .grpCfg   (grpCfg),
    .strb     (ctlStrb)
  );

  pwm_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .fastTick (fastTick),
    .slowTick (slowTick),
    .strb     (ctlStrb),
    .grpCfg   (grpCfg),
    .dutySh   (dutySh),
    .grpSel   (grpSel),
    .gateMask (gateMask),
    .polMask  (polMask),
    .pwmOut   (pwmOut)
  );
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            regAddr,
  input logic                         wrEn,
  input logic [DATA_W-1:0]            wrData,
  input logic [NUM_CH-1:0]            gateMask,
  input logic [NUM_CH-1:0]            polMask,
  input logic [NUM_CH-1:0][SEL_W-1:0] grpSel,
  input logic                         run,
  input logic [NUM_CH-1:0]            pwmOut
);
  // R8
  run_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (pwmOut == polMask));

  // R7
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pwmOut ^ polMask) & gateMask) == '0);

  // R2
  gate_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(A_GATE)) |=> (gateMask == $past(wrData[NUM_CH-1:0])));

  // R6
  pol_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(A_POL)) |=> (polMask == $past(wrData[NUM_CH-1:0])));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    // R9
    no_group_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grpSel[ch] == '0) |-> (pwmOut[ch] == polMask[ch]));
  end
endmodule

bind pwm_bank pwm_bank_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .gateMask (gateMask),
  .polMask  (polMask),
  .grpSel   (grpSel),
  .run      (ctlStrb.run),
  .pwmOut   (pwmOut)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       fastTick = 1'b1;
  logic       slowTick = 1'b0;
  logic [7:0] pwmOut;

  int totalCnt = 0;
  int badCnt = 0;
  int pushCnt = 0;
  int doneCnt = 0;

  typedef struct {
    int    ch;
    int    win;
    int    hi;
    int    rise;
    string tag;
  } item_t;
  item_t expQ [$];

  always #2 clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .fastTick(fastTick), .slowTick(slowTick), .pwmOut(pwmOut)
  );

  // slow reference: one tick every five clocks
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      badCnt++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(rdData == exp, tag, int'(rdData), int'(exp));
  endtask

  // driver side of the scoreboard
  task automatic expectWin(input int ch, input int win, input int hi, input int rise, input string tag);
    item_t it;
    it.ch = ch; it.win = win; it.hi = hi; it.rise = rise; it.tag = tag;
    expQ.push_back(it);
    pushCnt++;
    wait (doneCnt == pushCnt);
  endtask

  // monitor: measures each window and compares with the queued expectation
  initial begin
    forever begin
      item_t it;
      int hi;
      int rise;
      logic prev;
      wait (pushCnt > doneCnt);
      it = expQ.pop_front();
      hi = 0; rise = 0;
      @(negedge clk);
      prev = pwmOut[it.ch];
      repeat (it.win) begin
        @(negedge clk);
        if (pwmOut[it.ch]) hi++;
        if (!prev && pwmOut[it.ch]) rise++;
        prev = pwmOut[it.ch];
      end
      check(hi == it.hi, {it.tag, " high count"}, hi, it.hi);
      if (it.rise >= 0) check(rise == it.rise, {it.tag, " rising edges"}, rise, it.rise);
      doneCnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    badCnt++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("test done: total=%0d bad=%0d", totalCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(pwmOut == 8'h00, "R1 outputs after reset", int'(pwmOut), 0);
    rdChk(5'h0A, 8'hFF, "R1 gate reset value");
    rdChk(5'h00, 8'h00, "R1 duty reset value");
    rdChk(5'h0D, 8'h00, "R1 control reset value");

    // configuration while stopped
    wrReg(5'h10, 8'h01); wrReg(5'h11, 8'h00); wrReg(5'h12, 8'h09); // group 1: /2, /10
    wrReg(5'h14, 8'h00); wrReg(5'h15, 8'h00); wrReg(5'h16, 8'h03); // group 2: /1, /4
    wrReg(5'h18, 8'h00); wrReg(5'h19, 8'h00); wrReg(5'h1A, 8'h03); // group 3: /1, /4
    wrReg(5'h0C, 8'h0E);
    wrReg(5'h08, 8'h15);
    wrReg(5'h09, 8'h1E);
    wrReg(5'h00, 8'd3);  wrReg(5'h01, 8'd0);  wrReg(5'h02, 8'd200); wrReg(5'h03, 8'd5);
    wrReg(5'h04, 8'd1);  wrReg(5'h05, 8'd2);  wrReg(5'h06, 8'd3);   wrReg(5'h07, 8'd5);
    wrReg(5'h0A, 8'h00);

    // R2 readback
    rdChk(5'h09, 8'h1E, "R2 select high readback");
    rdChk(5'h0C, 8'h0E, "R2 reference select readback");
    rdChk(5'h16, 8'h03, "R2 group 2 limit readback");
    rdChk(5'h05, 8'h02, "R2 duty 5 readback");
    rdChk(5'h0F, 8'h00, "R2 unmapped reads zero");

    wrReg(5'h0D, 8'h02);
    repeat (60) @(negedge clk);

    expectWin(0, 40, 12, 2, "R4 ch0 duty 3 of 10 prescale 2");
    expectWin(1, 40, 0, 0, "R5 ch1 zero duty");
    expectWin(2, 40, 40, 0, "R4 ch2 duty above limit");
    expectWin(3, 40, 0, 0, "R9 ch3 group code 0");
    expectWin(7, 40, 0, 0, "R9 ch7 group code 0");
    expectWin(4, 40, 10, 10, "R9 ch4 group 2 via high select");
    expectWin(5, 40, 20, 10, "R10 ch5 group 3 on fast tick");

    wrReg(5'h0C, 8'h06);
    repeat (50) @(negedge clk);
    expectWin(5, 40, 20, 2, "R10 ch5 group 3 on slow tick");

    wrReg(5'h0B, 8'h01);
    repeat (5) @(negedge clk);
    expectWin(0, 40, 28, 2, "R6 ch0 inverted");

    wrReg(5'h0A, 8'h01);
    expectWin(0, 40, 40, 0, "R7 ch0 gated idle high");
    expectWin(6, 40, 12, 2, "R7 ch6 unaffected by ch0 gate");
    wrReg(5'h0B, 8'h00);
    expectWin(0, 40, 0, 0, "R7 ch0 gated idle low");
    wrReg(5'h0A, 8'h00);

    // R8 stopped state
    wrReg(5'h0B, 8'h80);
    wrReg(5'h0D, 8'h00);
    repeat (3) @(negedge clk);
    check(pwmOut == 8'h80, "R8 outputs follow polarity when stopped", int'(pwmOut), 8'h80);
    expectWin(2, 40, 0, 0, "R8 ch2 stays idle when stopped");
    wrReg(5'h0B, 8'h00);

    // R11 deferred duty update: group 1 period 100, high 50
    wrReg(5'h10, 8'h09); wrReg(5'h12, 8'h09);
    wrReg(5'h00, 8'd5);
    wrReg(5'h0D, 8'h02);
    @(negedge clk);
    check(pwmOut[0] == 1'b1, "R11 ch0 active at period start", int'(pwmOut[0]), 1);
    repeat (5) @(negedge clk);
    wrReg(5'h00, 8'd0);
    expectWin(0, 30, 30, 0, "R11 ch0 keeps old duty before wrap");
    repeat (70) @(negedge clk);
    expectWin(0, 100, 0, 0, "R11 ch0 takes zero duty after wrap");

    // R3 prescale high byte: 257 x 2 clocks
    wrReg(5'h0D, 8'h00);
    wrReg(5'h10, 8'h00); wrReg(5'h11, 8'h01); wrReg(5'h12, 8'h01);
    wrReg(5'h00, 8'd1);
    wrReg(5'h0D, 8'h02);
    repeat (20) @(negedge clk);
    expectWin(0, 514, 257, 1, "R3 ch0 prescale high byte period");

    $display("test done: total=%0d bad=%0d", totalCnt, badCnt);
    $finish;
  end
endmodule